// File: doc/BRIEF.md
# Load-Linked Reservation Capture Unit

This block performs the first half of an atomic read-modify-write: the linked load. A request brings a virtual address, a width select (32-bit word or 64-bit doubleword) and a debug-mode flag. The block checks the address alignment for the chosen width. A misaligned address produces a one-cycle exception pulse with a cause code and issues no memory read. When debug mode is off, the faulting address is also written into a bad-address register. An aligned address issues exactly one read on a valid/ready memory port.

When the read response comes back, the block records a reservation. The reservation holds the physical address, the virtual address and the loaded value, and a valid flag is set. The result also goes to the register file: a word is sign-extended to 64 bits, and a doubleword is passed through unchanged.

Address translation happens outside the block. The translated address arrives on an input port alongside the request. Matching store-conditional checks and coherence snooping clear the reservation through the invalidate input.

Top module: `ll_capture`

## Requirements
- R1: After reset, `busy`, `exc_valid`, `wb_valid`, `mem_req_valid` and `resv_valid` are 0, and `badaddr`, `resv_paddr`, `resv_vaddr` and `resv_data` are 0.
- R2: A word request (`req_dword`=0) with `req_vaddr[1:0]`≠0 is misaligned. A doubleword request (`req_dword`=1) with `req_vaddr[2:0]`≠0 is misaligned.
- R3: A misaligned request causes `exc_valid` to be high for exactly one cycle, on the cycle after the request is accepted. During that cycle `exc_cause` is 5'd4 (address error on load). No memory request is issued.
- R4: On a misaligned request with `req_debug`=0, `badaddr` takes the faulting virtual address. With `req_debug`=1, `badaddr` keeps its old value.
- R5: An aligned request raises `mem_req_valid` with `mem_addr` equal to the request's `req_paddr` and `mem_dword` equal to the width. The request stays held until `mem_req_ready` is seen high.
- R6: `busy` is high from the cycle after an aligned request is accepted until the cycle after `mem_rsp_valid` is seen. New requests are accepted only while `busy`=0.
- R7: When the response arrives, `resv_paddr`, `resv_vaddr` and `resv_data` are updated and `resv_valid` is set on the next cycle. `wb_valid` pulses for one cycle in that same cycle.
- R8: For a word load, `wb_data` and `resv_data` are bits [31:0] of the response, sign-extended to 64 bits. For a doubleword load, they are the 64-bit response unchanged.
- R9: A fault leaves `resv_paddr`, `resv_vaddr`, `resv_data` and `resv_valid` unchanged.
- R10: `inval` clears `resv_valid` on the next cycle. If a response arrives in the same cycle as `inval`, the response wins and `resv_valid` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load-linked request strobe |
| req_vaddr | input | 64 | Virtual address |
| req_paddr | input | 64 | Translated address |
| req_dword | input | 1 | 1 = doubleword, 0 = word |
| req_debug | input | 1 | Debug mode active |
| busy | output | 1 | Block occupied with a load |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_addr | output | 64 | Memory read address |
| mem_dword | output | 1 | Memory read width |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 5 | Exception cause code |
| badaddr | output | 64 | Bad virtual address register |
| wb_valid | output | 1 | Register-file write strobe |
| wb_data | output | 64 | Extended load result |
| inval | input | 1 | Reservation invalidate |
| resv_valid | output | 1 | Reservation held |
| resv_paddr | output | 64 | Reserved physical address |
| resv_vaddr | output | 64 | Reserved virtual address |
| resv_data | output | 64 | Reserved loaded value |

## Verification
The hardest case to reach is a response arriving in the same cycle as an invalidate. The bench holds back `mem_rsp_valid` under its own control and raises `inval` in exactly that cycle. It also checks that a misaligned request in debug mode leaves a previously written `badaddr` unchanged. To do that, it first causes a non-debug fault so that `badaddr` holds a known nonzero value.

// File: rtl/ll_capture.sv
module ll_capture #(
  parameter int XLEN = 64,
  parameter logic [4:0] CAUSE_ADEL = 5'd4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [XLEN-1:0] req_vaddr,
  input  logic [XLEN-1:0] req_paddr,
  input  logic            req_dword,
  input  logic            req_debug,
  output logic            busy,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_dword,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  output logic            exc_valid,
  output logic [4:0]      exc_cause,
  output logic [XLEN-1:0] badaddr,
  output logic            wb_valid,
  output logic [XLEN-1:0] wb_data,
  input  logic            inval,
  output logic            resv_valid,
  output logic [XLEN-1:0] resv_paddr,
  output logic [XLEN-1:0] resv_vaddr,
  output logic [XLEN-1:0] resv_data
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;
  state_t st;

  logic [XLEN-1:0] cur_vaddr;
  logic            cur_dword;

  wire accept  = req_valid && st == S_IDLE;
  wire misal   = req_dword ? (req_vaddr[2:0] != 3'b0) : (req_vaddr[1:0] != 2'b0);
  wire rsp_hit = st == S_WAIT && mem_rsp_valid;
  wire [XLEN-1:0] ext_data = cur_dword ? mem_rsp_data
                                       : {{(XLEN-32){mem_rsp_data[31]}}, mem_rsp_data[31:0]};

  assign busy          = st != S_IDLE;
  assign mem_req_valid = st == S_REQ;
  assign mem_dword     = cur_dword;
  assign exc_cause     = exc_valid ? CAUSE_ADEL : 5'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cur_vaddr  <= '0;
      cur_dword  <= 1'b0;
      mem_addr   <= '0;
      exc_valid  <= 1'b0;
      badaddr    <= '0;
      wb_valid   <= 1'b0;
      wb_data    <= '0;
      resv_valid <= 1'b0;
      resv_paddr <= '0;
      resv_vaddr <= '0;
      resv_data  <= '0;
    end else begin
      exc_valid <= 1'b0;
      wb_valid  <= 1'b0;
      if (inval) resv_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (misal) begin
            exc_valid <= 1'b1;
            if (!req_debug) badaddr <= req_vaddr;
          end else begin
            st        <= S_REQ;
            cur_vaddr <= req_vaddr;
            cur_dword <= req_dword;
            mem_addr  <= req_paddr;
          end
        end
        S_REQ: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          st         <= S_IDLE;
          wb_valid   <= 1'b1;
          wb_data    <= ext_data;
          resv_valid <= 1'b1;
          resv_paddr <= mem_addr;
          resv_vaddr <= cur_vaddr;
          resv_data  <= ext_data;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_EXC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !exc_valid); // R3
  AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> exc_cause == CAUSE_ADEL); // R3
  AST_FAULT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && misal) |=> !mem_req_valid && !busy); // R3
  AST_DEBUG_KEEPS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && misal && req_debug) |=> $stable(badaddr)); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_addr)); // R5
  AST_FAULT_KEEPS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> $stable(resv_paddr) && $stable(resv_vaddr) && $stable(resv_data)); // R9
  AST_RSP_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |=> resv_valid && wb_valid); // R10
  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inval && !rsp_hit) |=> !resv_valid); // R10

endmodule

// File: tb/ll_capture_tb.sv
module ll_capture_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_dword = 0, req_debug = 0;
  logic [63:0] req_vaddr = '0, req_paddr = '0;
  logic mem_req_ready = 0, mem_rsp_valid = 0, inval = 0;
  logic [63:0] mem_rsp_data = '0;
  logic busy, mem_req_valid, mem_dword, exc_valid, wb_valid, resv_valid;
  logic [4:0] exc_cause;
  logic [63:0] mem_addr, badaddr, wb_data, resv_paddr, resv_vaddr, resv_data;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ll_capture dut_i (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic issue(logic [63:0] va, logic [63:0] pa, logic dw, logic dbg);
    req_vaddr = va; req_paddr = pa; req_dword = dw; req_debug = dbg; req_valid = 1;
    cyc();
    req_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 exc", exc_valid, 0); chk("R1 wb", wb_valid, 0);
    chk("R1 memreq", mem_req_valid, 0); chk("R1 resv_valid", resv_valid, 0);
    chk("R1 badaddr", badaddr, 0); chk("R1 resv_data", resv_data, 0);
    chk("R1 resv_paddr", resv_paddr, 0);
  endtask

  task automatic t_fault(logic [63:0] va, logic dw, logic dbg, logic [63:0] exp_bad);
    logic [63:0] rp = resv_paddr, rd = resv_data;
    logic rv = resv_valid;
    issue(va, 64'h5555, dw, dbg);
    chk("R2/R3 exc pulse", exc_valid, 1);
    chk("R3 cause", exc_cause, 5'd4);
    chk("R3 no memreq", mem_req_valid, 0);
    chk("R4 badaddr", badaddr, exp_bad);
    chk("R9 resv_paddr", resv_paddr, rp);
    chk("R9 resv_data", resv_data, rd);
    chk("R9 resv_valid", resv_valid, rv);
    cyc();
    chk("R3 exc one cycle", exc_valid, 0);
  endtask

  task automatic t_load(logic [63:0] va, logic [63:0] pa, logic dw, logic [63:0] rdata,
                        logic [63:0] exp, int stall, logic with_inval);
    issue(va, pa, dw, 0);
    chk("R2 aligned no exc", exc_valid, 0);
    chk("R5 memreq", mem_req_valid, 1);
    chk("R5 addr", mem_addr, pa);
    chk("R5 width", mem_dword, dw);
    chk("R6 busy", busy, 1);
    for (int i = 0; i < stall; i++) begin
      cyc();
      chk("R5 held", mem_req_valid, 1);
    end
    mem_req_ready = 1; cyc(); mem_req_ready = 0;
    chk("R5 dropped", mem_req_valid, 0);
    chk("R6 busy wait", busy, 1);
    mem_rsp_valid = 1; mem_rsp_data = rdata; inval = with_inval;
    cyc();
    mem_rsp_valid = 0; inval = 0;
    chk("R7 wb pulse", wb_valid, 1);
    chk("R8 wb_data", wb_data, exp);
    chk("R8 resv_data", resv_data, exp);
    chk("R7 resv_paddr", resv_paddr, pa);
    chk("R7 resv_vaddr", resv_vaddr, va);
    chk(with_inval ? "R10 rsp wins" : "R7 resv_valid", resv_valid, 1);
    chk("R6 busy clear", busy, 0);
    cyc();
    chk("R7 wb one cycle", wb_valid, 0);
  endtask

  task automatic t_inval();
    inval = 1; cyc(); inval = 0;
    chk("R10 inval clears", resv_valid, 0);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1; #1;
    t_reset();
    t_fault(64'h1002, 0, 0, 64'h1002);
    t_fault(64'h2004, 1, 1, 64'h1002);
    t_fault(64'h3003, 0, 1, 64'h1002);
    t_fault(64'h4004, 1, 0, 64'h4004);
    t_load(64'h8004, 64'hA004, 0, 64'h1234_5678_8000_0001, 64'hFFFF_FFFF_8000_0001, 2, 0);
    t_fault(64'h9001, 0, 0, 64'h9001);
    t_load(64'h8010, 64'hB010, 0, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF, 0, 0);
    t_inval();
    t_load(64'hC008, 64'hD008, 1, 64'h8765_4321_0FED_CBA9, 64'h8765_4321_0FED_CBA9, 1, 1);
    t_inval();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule